// File: doc/BRIEF.md
# Multi-Discipline Egress Queue Scheduler

This block decides which of up to eight egress queues sends its next packet. Each queue reports whether it holds a packet and the length of the packet at its head. The block picks one queue with the discipline chosen in a mode register: plain round robin, byte-accurate deficit weighted round robin, or strict priority. Each queue also has an enable bit, a quantum (its weight, in bytes per visit) and a priority value.

A chosen queue is offered downstream as an index and a one-hot vector. The offer is held until the downstream shaper or MAC raises its ready input. The grant-valid output is high for exactly the cycle in which the packet is accepted, so the queue logic pops its head on that clock edge.

After each acceptance the block spends at least one cycle choosing again. This gives the queue flags time to reflect the pop. A new mode written to the mode register takes effect only when no packet offer is pending.

Top module: `egress_sched`

## Requirements
- R1: After synchronous reset, grant_valid is 0, grant_onehot is all zeros, grant_idx is 0 and the active mode is round robin.
- R2: grant_valid is high only while tx_ready is high. Once a queue has been chosen, grant_idx holds that queue for as long as tx_ready stays low.
- R3: grant_onehot has bit grant_idx set and no other bit while grant_valid is high, and is all zeros otherwise.
- R4: In round-robin mode (code 0, and also code 3), each eligible queue sends one packet per turn. The search starts at the queue after the last accepted one and wraps from the top index to 0. After reset the search starts at queue 0.
- R5: In deficit mode (code 1), the queue under the pointer gains its quantum once per visit. It sends head packets while the head length does not exceed its deficit, and each length sent is subtracted from the deficit. When the head no longer fits, the pointer moves on and the remaining deficit is kept.
- R6: In deficit mode, a queue whose quantum is 0 is never granted.
- R7: In priority mode (code 2), the eligible queue with the numerically largest priority value is granted, so a higher-valued queue drains fully before any lower one is served.
- R8: In priority mode, among eligible queues with equal priority, the lowest index wins.
- R9: A queue whose enable bit is 0 is never granted, in any mode.
- R10: A mode written through cfg_mode/cfg_mode_wr while an offer is pending does not alter that offer. It governs the choices made after the offer is accepted.
- R11: A queue's deficit is reset to 0 when the queue becomes empty. A refilled queue starts again from its quantum alone.
- R12: A grant is only ever given to a queue that is enabled and non-empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 2 | Mode to latch: 0 round robin, 1 deficit, 2 priority, 3 round robin |
| cfg_mode_wr | input | 1 | Write strobe for cfg_mode |
| q_enable | input | NQ | Per-queue enable |
| q_quantum | input | NQ x QW | Per-queue quantum in bytes |
| q_prio | input | NQ x PW | Per-queue priority, larger is more urgent |
| q_nonempty | input | NQ | Queue holds at least one packet |
| q_head_len | input | NQ x LW | Length of the head packet of each queue |
| tx_ready | input | 1 | Downstream can accept a packet this cycle |
| grant_valid | output | 1 | Packet of the chosen queue accepted this cycle |
| grant_onehot | output | NQ | One-hot form of the accepted queue |
| grant_idx | output | clog2(NQ) | Index of the chosen queue, held while waiting |

## Verification
The bench builds the scheduler with four queues, 10-bit lengths and quanta, and 2-bit priorities. Four queues make index wrap-around, a zero-quantum queue, a disabled queue and a priority tie all fit in a few packets. Lengths of up to 1023 bytes let deficits build up over several pointer visits before a long packet fits. With those values, expected grant orders can be worked out by hand. One order includes a refill made one cycle after a queue drained, which shows whether the emptied queue's deficit was reset.

// File: rtl/egress_sched_pkg.sv
package egress_sched_pkg;

    typedef enum logic [1:0] {
        MODE_RR   = 2'd0,
        MODE_DWRR = 2'd1,
        MODE_PRIO = 2'd2,
        MODE_RSVD = 2'd3
    } sched_mode_e;

    typedef enum logic {
        ST_PICK  = 1'b0,
        ST_OFFER = 1'b1
    } sched_state_e;

    function automatic int max_w(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/egress_rr_pick.sv
module egress_rr_pick #(
    parameter int NQ = 8,
    parameter int IW = 3
) (
    input  logic [NQ-1:0] req,
    input  logic [IW-1:0] start,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int k = 0; k < NQ; k++) begin
            int c;
            c = int'(start) + k;
            if (c >= NQ) c = c - NQ;
            if (!found && req[c]) begin
                found = 1'b1;
                idx   = IW'(c);
            end
        end
    end
endmodule

// File: rtl/egress_prio_pick.sv
module egress_prio_pick #(
    parameter int NQ = 8,
    parameter int IW = 3,
    parameter int PW = 3
) (
    input  logic [NQ-1:0]         req,
    input  logic [NQ-1:0][PW-1:0] prio,
    output logic                  found,
    output logic [IW-1:0]         idx
);
    logic [PW-1:0] best;

    always_comb begin
        found = 1'b0;
        idx   = '0;
        best  = '0;
        for (int i = 0; i < NQ; i++) begin
            if (req[i] && (!found || prio[i] > best)) begin
                found = 1'b1;
                idx   = IW'(i);
                best  = prio[i];
            end
        end
    end
endmodule

// File: rtl/egress_dwrr_step.sv
module egress_dwrr_step #(
    parameter int DW = 13,
    parameter int QW = 12,
    parameter int LW = 12
) (
    input  logic          eligible,
    input  logic          nonempty,
    input  logic          fresh,
    input  logic [DW-1:0] deficit,
    input  logic [QW-1:0] quantum,
    input  logic [LW-1:0] head_len,
    output logic          send,
    output logic          advance,
    output logic [DW-1:0] deficit_nxt
);
    logic [DW-1:0] credited;
    logic [DW-1:0] len_ext;

    always_comb begin
        len_ext  = DW'(head_len);
        credited = fresh ? deficit + DW'(quantum) : deficit;
        send     = eligible && (len_ext <= credited);
        advance  = !send;
        if (send)
            deficit_nxt = credited - len_ext;
        else if (eligible)
            deficit_nxt = credited;
        else if (nonempty)
            deficit_nxt = deficit;
        else
            deficit_nxt = '0;
    end
endmodule

// File: rtl/egress_sched.sv
module egress_sched
    import egress_sched_pkg::*;
#(
    parameter int NQ = 8,
    parameter int LW = 12,
    parameter int QW = 12,
    parameter int PW = 3,
    localparam int IW = (NQ > 1) ? $clog2(NQ) : 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [1:0]            cfg_mode,
    input  logic                  cfg_mode_wr,
    input  logic [NQ-1:0]         q_enable,
    input  logic [NQ-1:0][QW-1:0] q_quantum,
    input  logic [NQ-1:0][PW-1:0] q_prio,
    input  logic [NQ-1:0]         q_nonempty,
    input  logic [NQ-1:0][LW-1:0] q_head_len,
    input  logic                  tx_ready,
    output logic                  grant_valid,
    output logic [NQ-1:0]         grant_onehot,
    output logic [IW-1:0]         grant_idx
);
    localparam int DW = max_w(LW, QW) + 1;

    sched_state_e          state_q;
    sched_mode_e           mode_req_q, mode_act_q;
    logic [IW-1:0]         sel_q, rr_ptr_q, dw_ptr_q;
    logic                  fresh_q;
    logic [NQ-1:0][DW-1:0] def_q;

    logic [NQ-1:0] elig;
    logic [NQ-1:0] dw_elig;
    logic          any_dw;
    logic          offering;

    assign elig     = q_enable & q_nonempty;
    assign any_dw   = |dw_elig;
    assign offering = (state_q == ST_OFFER);

    for (genvar g = 0; g < NQ; g++) begin : g_elig
        assign dw_elig[g] = elig[g] && (q_quantum[g] != '0);
    end

    logic          rr_found, pr_found;
    logic [IW-1:0] rr_idx, pr_idx;
    logic          dw_send, dw_adv;
    logic [DW-1:0] dw_def_nxt;

    egress_rr_pick #(.NQ(NQ), .IW(IW)) u_rr (
        .req   (elig),
        .start (rr_ptr_q),
        .found (rr_found),
        .idx   (rr_idx)
    );

    egress_prio_pick #(.NQ(NQ), .IW(IW), .PW(PW)) u_prio (
        .req   (elig),
        .prio  (q_prio),
        .found (pr_found),
        .idx   (pr_idx)
    );

    egress_dwrr_step #(.DW(DW), .QW(QW), .LW(LW)) u_dw (
        .eligible    (dw_elig[dw_ptr_q]),
        .nonempty    (q_nonempty[dw_ptr_q]),
        .fresh       (fresh_q),
        .deficit     (def_q[dw_ptr_q]),
        .quantum     (q_quantum[dw_ptr_q]),
        .head_len    (q_head_len[dw_ptr_q]),
        .send        (dw_send),
        .advance     (dw_adv),
        .deficit_nxt (dw_def_nxt)
    );

    logic          pick_ok;
    logic [IW-1:0] pick_idx;

    always_comb begin
        unique case (mode_req_q)
            MODE_DWRR: begin pick_ok = dw_send;  pick_idx = dw_ptr_q; end
            MODE_PRIO: begin pick_ok = pr_found; pick_idx = pr_idx;   end
            default:   begin pick_ok = rr_found; pick_idx = rr_idx;   end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_PICK;
            mode_req_q <= MODE_RR;
            mode_act_q <= MODE_RR;
            sel_q      <= '0;
            rr_ptr_q   <= '0;
            dw_ptr_q   <= '0;
            fresh_q    <= 1'b1;
            def_q      <= '0;
        end else begin
            if (cfg_mode_wr) mode_req_q <= sched_mode_e'(cfg_mode);
            for (int i = 0; i < NQ; i++) begin
                if (!q_nonempty[i]) def_q[i] <= '0;
            end
            unique case (state_q)
                ST_PICK: begin
                    mode_act_q <= mode_req_q;
                    if (mode_req_q == MODE_DWRR && any_dw) begin
                        def_q[dw_ptr_q] <= dw_def_nxt;
                        fresh_q         <= dw_adv;
                        if (dw_adv)
                            dw_ptr_q <= (dw_ptr_q == IW'(NQ-1)) ? '0 : dw_ptr_q + 1'b1;
                    end
                    if (pick_ok) begin
                        sel_q   <= pick_idx;
                        state_q <= ST_OFFER;
                    end
                end
                ST_OFFER: begin
                    if (tx_ready) begin
                        state_q <= ST_PICK;
                        if (mode_act_q == MODE_RR || mode_act_q == MODE_RSVD)
                            rr_ptr_q <= (sel_q == IW'(NQ-1)) ? '0 : sel_q + 1'b1;
                    end
                end
                default: state_q <= ST_PICK;
            endcase
        end
    end

    assign grant_valid = offering && tx_ready;
    assign grant_idx   = sel_q;

    for (genvar g = 0; g < NQ; g++) begin : g_oh
        assign grant_onehot[g] = grant_valid && (sel_q == IW'(g));
    end

endmodule

// File: rtl/egress_sched_chk.sv
module egress_sched_chk
    import egress_sched_pkg::*;
#(
    parameter int NQ = 8,
    parameter int QW = 12,
    parameter int IW = 3
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  tx_ready,
    input logic [NQ-1:0]         q_enable,
    input logic [NQ-1:0]         q_nonempty,
    input logic [NQ-1:0][QW-1:0] q_quantum,
    input logic                  grant_valid,
    input logic [NQ-1:0]         grant_onehot,
    input logic [IW-1:0]         grant_idx,
    input logic                  offering,
    input logic [1:0]            mode_act
);
    p_valid_needs_ready_r2: assert property (@(posedge clk) disable iff (rst)
        grant_valid |-> tx_ready);

    p_hold_choice_r2: assert property (@(posedge clk) disable iff (rst)
        (offering && !tx_ready) |=> (offering && $stable(grant_idx)));

    p_onehot_shape_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant_onehot));

    p_onehot_match_r3: assert property (@(posedge clk) disable iff (rst)
        grant_valid |-> (grant_onehot[grant_idx] && $countones(grant_onehot) == 1));

    p_onehot_idle_r3: assert property (@(posedge clk) disable iff (rst)
        !grant_valid |-> (grant_onehot == '0));

    p_grant_eligible_r12: assert property (@(posedge clk) disable iff (rst)
        grant_valid |-> (q_nonempty[grant_idx] && q_enable[grant_idx]));

    p_zero_quantum_r6: assert property (@(posedge clk) disable iff (rst)
        (grant_valid && mode_act == MODE_DWRR) |-> (q_quantum[grant_idx] != '0));

    p_mode_frozen_r10: assert property (@(posedge clk) disable iff (rst)
        offering |=> $stable(mode_act));

endmodule

bind egress_sched egress_sched_chk #(.NQ(NQ), .QW(QW), .IW(IW)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .tx_ready     (tx_ready),
    .q_enable     (q_enable),
    .q_nonempty   (q_nonempty),
    .q_quantum    (q_quantum),
    .grant_valid  (grant_valid),
    .grant_onehot (grant_onehot),
    .grant_idx    (grant_idx),
    .offering     (offering),
    .mode_act     (mode_act_q)
);

// File: tb/egress_sched_tb.sv
module egress_sched_tb;
    localparam int NQ = 4;
    localparam int LW = 10;
    localparam int QW = 10;
    localparam int PW = 2;
    localparam int IW = 2;

    logic                  clk = 1'b0;
    logic                  rst = 1'b1;
    logic [1:0]            cfg_mode = 2'd0;
    logic                  cfg_mode_wr = 1'b0;
    logic [NQ-1:0]         q_enable = '0;
    logic [NQ-1:0][QW-1:0] q_quantum = '0;
    logic [NQ-1:0][PW-1:0] q_prio = '0;
    logic [NQ-1:0]         q_nonempty;
    logic [NQ-1:0][LW-1:0] q_head_len;
    logic                  tx_ready = 1'b0;
    logic                  grant_valid;
    logic [NQ-1:0]         grant_onehot;
    logic [IW-1:0]         grant_idx;

    always #10 clk = ~clk;

    egress_sched #(.NQ(NQ), .LW(LW), .QW(QW), .PW(PW)) u_dut (
        .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_mode_wr(cfg_mode_wr),
        .q_enable(q_enable), .q_quantum(q_quantum), .q_prio(q_prio),
        .q_nonempty(q_nonempty), .q_head_len(q_head_len), .tx_ready(tx_ready),
        .grant_valid(grant_valid), .grant_onehot(grant_onehot), .grant_idx(grant_idx)
    );

    // queue model: packet lengths, head and tail counters per queue
    int plen [NQ][8];
    int hd [NQ];
    int tl [NQ];

    always_comb begin
        for (int i = 0; i < NQ; i++) begin
            q_nonempty[i] = hd[i] < tl[i];
            q_head_len[i] = (hd[i] < tl[i]) ? LW'(plen[i][hd[i] % 8]) : '0;
        end
    end

    int    n_run = 0;
    int    n_fail = 0;
    int    cyc = 0;
    bit    done = 0;
    int    exp_q[$];
    string tag_q[$];
    string idle_req = "R4";

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic expect_grant(input int idx, input string req);
        exp_q.push_back(idx);
        tag_q.push_back(req);
    endtask

    // monitor: pops the model on acceptance and compares with the scoreboard
    always @(posedge clk) begin
        if (!rst && grant_valid) begin
            hd[grant_idx] <= hd[grant_idx] + 1;
            chk((hd[grant_idx] < tl[grant_idx]) && q_enable[grant_idx], "R12",
                "granted queue not eligible", int'(grant_idx), -1);
            chk(int'(grant_onehot) == (1 << grant_idx), "R3", "onehot vs index",
                int'(grant_onehot), 1 << grant_idx);
            if (exp_q.size() == 0) begin
                chk(1'b0, idle_req, "unexpected grant", int'(grant_idx), -1);
            end else begin
                int    e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(int'(grant_idx) == e, t, "grant order", int'(grant_idx), e);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    task automatic put(input int q, input int slot, input int len);
        plen[q][slot] <= len;
    endtask

    task automatic begin_scn(input logic [1:0] m);
        @(negedge clk);
        rst = 1'b1;
        tx_ready = 1'b0;
        q_enable = '0;
        for (int i = 0; i < NQ; i++) begin
            hd[i] <= 0;
            tl[i] <= 0;
        end
        repeat (2) @(negedge clk);
        rst = 1'b0;
        cfg_mode = m;
        cfg_mode_wr = 1'b1;
        @(negedge clk);
        cfg_mode_wr = 1'b0;
    endtask

    task automatic drain(input string req);
        int t;
        t = 0;
        while (exp_q.size() != 0 && t < 3000) begin
            @(negedge clk);
            t++;
        end
        chk(exp_q.size() == 0, req, "grants still pending", exp_q.size(), 0);
        exp_q.delete();
        tag_q.delete();
    endtask

    initial begin
        for (int i = 0; i < NQ; i++) begin
            hd[i] = 0;
            tl[i] = 0;
        end
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(grant_valid == 1'b0, "R1", "grant_valid in reset", int'(grant_valid), 0);
        chk(grant_onehot == '0, "R1", "grant_onehot in reset", int'(grant_onehot), 0);
        chk(grant_idx == '0, "R1", "grant_idx in reset", int'(grant_idx), 0);

        // R4: round robin rotation with wrap
        begin_scn(2'd0);
        put(0,0,64); put(0,1,64); put(0,2,64); put(1,0,64); put(2,0,64); put(2,1,64);
        tl[0] <= 3; tl[1] <= 1; tl[2] <= 2;
        expect_grant(0,"R4"); expect_grant(1,"R4"); expect_grant(2,"R4");
        expect_grant(0,"R4"); expect_grant(2,"R4"); expect_grant(0,"R4");
        @(negedge clk);
        q_enable = 4'b1111; tx_ready = 1'b1;
        drain("R4");

        // R9: disabled queue skipped and left untouched
        begin_scn(2'd3);
        put(0,0,64); put(0,1,64); put(1,0,64); put(2,0,64); put(2,1,64); put(3,0,64);
        tl[0] <= 2; tl[1] <= 1; tl[2] <= 2; tl[3] <= 1;
        expect_grant(0,"R9"); expect_grant(1,"R9"); expect_grant(3,"R9"); expect_grant(0,"R9");
        @(negedge clk);
        q_enable = 4'b1011; tx_ready = 1'b1;
        drain("R9");
        idle_req = "R9";
        repeat (20) @(negedge clk);
        chk(hd[2] == 0 && q_nonempty[2], "R9", "disabled queue popped", hd[2], 0);
        idle_req = "R4";

        // R2 / R3: offer held while ready is low
        begin_scn(2'd0);
        put(1,0,64); put(2,0,64);
        tl[1] <= 1; tl[2] <= 1;
        @(negedge clk);
        q_enable = 4'b0110;
        repeat (5) @(negedge clk);
        chk(grant_valid == 1'b0, "R2", "valid without ready", int'(grant_valid), 0);
        chk(grant_idx == 2'd1, "R2", "chosen index", int'(grant_idx), 1);
        chk(grant_onehot == '0, "R3", "onehot while waiting", int'(grant_onehot), 0);
        repeat (3) @(negedge clk);
        chk(grant_idx == 2'd1, "R2", "index held", int'(grant_idx), 1);
        expect_grant(1,"R2"); expect_grant(2,"R4");
        tx_ready = 1'b1;
        drain("R2");

        // R5 / R6: deficit round robin with a zero-quantum queue
        begin_scn(2'd1);
        q_quantum[0] = 10'd100; q_quantum[1] = 10'd50;
        q_quantum[2] = 10'd0;   q_quantum[3] = 10'd100;
        put(0,0,60); put(0,1,60); put(0,2,60); put(1,0,80); put(1,1,30);
        put(2,0,10); put(3,0,150); put(3,1,20);
        tl[0] <= 3; tl[1] <= 2; tl[2] <= 1; tl[3] <= 2;
        expect_grant(0,"R5"); expect_grant(0,"R5"); expect_grant(0,"R5");
        expect_grant(1,"R5"); expect_grant(3,"R5"); expect_grant(3,"R5");
        expect_grant(1,"R5");
        @(negedge clk);
        q_enable = 4'b1111; tx_ready = 1'b1;
        drain("R5");
        idle_req = "R6";
        repeat (30) @(negedge clk);
        chk(hd[2] == 0 && q_nonempty[2], "R6", "zero-quantum queue popped", hd[2], 0);
        idle_req = "R4";

        // R11: deficit reset when a queue empties, then refill
        begin_scn(2'd1);
        q_quantum = '0;
        q_quantum[0] = 10'd100; q_quantum[1] = 10'd100;
        put(0,0,30); put(1,0,90); put(1,1,90);
        tl[0] <= 1; tl[1] <= 2;
        expect_grant(0,"R5"); expect_grant(1,"R5"); expect_grant(1,"R5");
        expect_grant(0,"R11");
        @(negedge clk);
        q_enable = 4'b0011; tx_ready = 1'b1;
        begin
            bit seen;
            seen = 1'b0;
            while (!seen) begin
                @(posedge clk);
                seen = grant_valid;
            end
        end
        @(posedge clk);
        @(negedge clk);
        put(0,1,150);
        tl[0] <= 2;
        drain("R11");

        // R7 / R8: strict priority with a tie
        begin_scn(2'd2);
        q_prio[0] = 2'd1; q_prio[1] = 2'd3; q_prio[2] = 2'd3; q_prio[3] = 2'd0;
        put(0,0,64); put(0,1,64); put(1,0,64); put(1,1,64); put(2,0,64); put(3,0,64);
        tl[0] <= 2; tl[1] <= 2; tl[2] <= 1; tl[3] <= 1;
        expect_grant(1,"R8"); expect_grant(1,"R7"); expect_grant(2,"R7");
        expect_grant(0,"R7"); expect_grant(0,"R7"); expect_grant(3,"R7");
        @(negedge clk);
        q_enable = 4'b1111; tx_ready = 1'b1;
        drain("R7");

        // R10: mode written while an offer is pending
        begin_scn(2'd0);
        q_prio = '0;
        q_prio[2] = 2'd3;
        put(0,0,64); put(0,1,64); put(1,0,64); put(2,0,64);
        tl[0] <= 2; tl[1] <= 1; tl[2] <= 1;
        @(negedge clk);
        q_enable = 4'b1111;
        repeat (3) @(negedge clk);
        cfg_mode = 2'd2; cfg_mode_wr = 1'b1;
        @(negedge clk);
        cfg_mode_wr = 1'b0;
        repeat (2) @(negedge clk);
        chk(grant_idx == 2'd0, "R10", "pending offer changed", int'(grant_idx), 0);
        expect_grant(0,"R10"); expect_grant(2,"R10"); expect_grant(0,"R8"); expect_grant(1,"R10");
        tx_ready = 1'b1;
        drain("R10");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule